// File: doc/BRIEF.md
# DRAM Channel Command Timing Arbiter

This block sits between the per-bank schedulers of a DRAM controller and the shared command bus of one channel. Each bank scheduler presents at most one candidate command at a time: precharge, activate, read or write. Each candidate carries an arrival stamp. In every DRAM clock the arbiter works out which candidates the channel can legally take. It then puts exactly one of them on the bus and returns a single-cycle acknowledge to the bank that supplied it. A bank keeps its candidate asserted until that acknowledge arrives.

The arbiter enforces only channel-wide timing. It spaces activates by a minimum distance and caps the number of activates in a rolling window. It also guards the data bus: a read may not follow a write too soon, a write may not follow a read too soon, and same-direction bursts may not overlap. Among the legal candidates the oldest stamp wins, and equal stamps go to the lower bank index. A blocked old request therefore never holds back a younger one that the channel can serve at once. Per-bank timing, refresh, ranks and power-down belong to other blocks.

Top module: `chan_cmd_arbiter`

## Requirements
- R1: The block issues at most one command per clock, and it issues one whenever at least one candidate is legal. When it issues, `ack` is one-hot on `issue_bank`, and `issue_kind` equals that bank's candidate kind. Kind encoding: 0 = precharge, 1 = activate, 2 = read, 3 = write. When nothing is legal, `issue_valid` and `ack` are both zero.
- R2: Two activates are never issued fewer than T_RRD (default 4) clocks apart.
- R3: At most four activates fall within any T_FAW (default 20) clock span. A further activate waits until T_FAW clocks after the oldest of the last four.
- R4: A read follows the most recent write by at least WL + BL/2 + T_WTR clocks (default 16).
- R5: A write follows the most recent read by at least CL + BL/2 + 2 - WL clocks (default 8).
- R6: Two reads, or two writes, are at least BL/2 clocks apart (default 4), because each burst holds the data bus for that long.
- R7: A precharge candidate is always legal, so an offered precharge means some command issues in that clock.
- R8: Of the legal candidates, the one with the smallest arrival stamp is issued. Equal stamps go to the lower bank index. Candidates that are not legal do not take part in the choice.
- R9: After reset no timing history remains. With no candidate, nothing is acknowledged. Any kind offered first is issued in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | NUM_BANKS | Per-bank candidate present |
| cand_kind | input | NUM_BANKS x 2 | Per-bank command kind (0 pre, 1 act, 2 rd, 3 wr) |
| cand_stamp | input | NUM_BANKS x STAMP_W | Per-bank arrival stamp; smaller is older |
| ack | output | NUM_BANKS | One-hot acknowledge to the bank whose candidate issued |
| issue_valid | output | 1 | A command is on the bus this clock |
| issue_bank | output | BANK_W | Bank index of the issued command |
| issue_kind | output | 2 | Kind of the issued command |

## Verification
The case hardest to reach is the rolling activate window. The window only closes when four activates have already gone out, spaced exactly at the minimum distance, and a fifth is waiting behind them. A directed sequence offers activates on all banks at once and re-offers the first bank the moment it is acknowledged, so the fifth activate runs into the closed window. Reordering past a blocked older read is reached the same way: a write is issued just before an old read and a younger write and precharge are offered. Random rounds with repeated stamps then mix all kinds against a cycle-level model of every rule.

// File: rtl/cta_pkg.sv
package cta_pkg;
   typedef enum logic [1:0] {
      CMD_PRE = 2'd0,
      CMD_ACT = 2'd1,
      CMD_RD  = 2'd2,
      CMD_WR  = 2'd3
   } dram_cmd_e;
endpackage

// File: rtl/cta_act_window.sv
module cta_act_window #(
   parameter int T_RRD    = 4,
   parameter int T_FAW    = 20,
   parameter int FAW_ACTS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_fire,
   output logic act_ok
);
   localparam int RRD_W = $clog2(T_RRD + 1);

   logic [RRD_W-1:0] rrd_cnt;
   logic             faw_ok;

   // spacing counter: zero means another activate may go
   always_ff @(posedge clk) begin
      if (!rst_n)                 rrd_cnt <= '0;
      else if (act_fire)          rrd_cnt <= RRD_W'(T_RRD - 1);
      else if (rrd_cnt != '0)     rrd_cnt <= rrd_cnt - 1'b1;
   end

   generate
      if (FAW_ACTS == 0) begin : g_no_window
         assign faw_ok = 1'b1;
      end else begin : g_window
         localparam int AGE_W = $clog2(T_FAW + 1);
         logic [AGE_W-1:0]    age_q [FAW_ACTS];
         logic [FAW_ACTS-1:0] slot_v;

         function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
            return (a >= AGE_W'(T_FAW)) ? a : a + 1'b1;
         endfunction

         for (genvar g = 0; g < FAW_ACTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  age_q[g]  <= '0;
                  slot_v[g] <= 1'b0;
               end else if (act_fire) begin
                  if (g == 0) begin
                     age_q[g]  <= AGE_W'(1);
                     slot_v[g] <= 1'b1;
                  end else begin
                     age_q[g]  <= age_step(age_q[(g == 0) ? 0 : g-1]);
                     slot_v[g] <= slot_v[(g == 0) ? 0 : g-1];
                  end
               end else begin
                  age_q[g] <= age_step(age_q[g]);
               end
            end
         end

         assign faw_ok = !slot_v[FAW_ACTS-1] || (age_q[FAW_ACTS-1] >= AGE_W'(T_FAW));
      end
   endgenerate

   assign act_ok = (rrd_cnt == '0) && faw_ok;

   // independent distance counter for checking activate spacing
   logic [RRD_W-1:0] since_act;
   always_ff @(posedge clk) begin
      if (!rst_n)                           since_act <= RRD_W'(T_RRD);
      else if (act_fire)                    since_act <= RRD_W'(1);
      else if (since_act != RRD_W'(T_RRD))  since_act <= since_act + 1'b1;
   end

   assert_act_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |-> since_act >= RRD_W'(T_RRD));

endmodule

// File: rtl/cta_bus_turn.sv
module cta_bus_turn #(
   parameter int W2R   = 16,
   parameter int R2W   = 8,
   parameter int BURST = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_fire,
   input  logic wr_fire,
   output logic rd_ok,
   output logic wr_ok
);
   localparam int MAX_A = (W2R > R2W) ? W2R : R2W;
   localparam int MAXC  = (MAX_A > BURST) ? MAX_A : BURST;
   localparam int CW    = $clog2(MAXC + 1);

   logic [CW-1:0] rd_hold, wr_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_hold <= '0;
         wr_hold <= '0;
      end else if (rd_fire) begin
         rd_hold <= CW'(BURST - 1);
         wr_hold <= CW'(R2W - 1);
      end else if (wr_fire) begin
         wr_hold <= CW'(BURST - 1);
         rd_hold <= CW'(W2R - 1);
      end else begin
         if (rd_hold != '0) rd_hold <= rd_hold - 1'b1;
         if (wr_hold != '0) wr_hold <= wr_hold - 1'b1;
      end
   end

   assign rd_ok = (rd_hold == '0);
   assign wr_ok = (wr_hold == '0);

   // independent clock distances since the last read and last write
   logic [CW-1:0] since_rd, since_wr;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rd <= CW'(MAXC);
         since_wr <= CW'(MAXC);
      end else begin
         if (rd_fire)                    since_rd <= CW'(1);
         else if (since_rd != CW'(MAXC)) since_rd <= since_rd + 1'b1;
         if (wr_fire)                    since_wr <= CW'(1);
         else if (since_wr != CW'(MAXC)) since_wr <= since_wr + 1'b1;
      end
   end

   assert_wr_to_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |-> since_wr >= CW'(W2R));
   assert_rd_to_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> since_rd >= CW'(R2W));
   assert_burst_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |-> since_rd >= CW'(BURST));
   assert_burst_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> since_wr >= CW'(BURST));

endmodule

// File: rtl/cta_oldest_pick.sv
module cta_oldest_pick #(
   parameter int NUM_BANKS = 4,
   parameter int STAMP_W   = 8,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [NUM_BANKS-1:0]              legal,
   input  logic [NUM_BANKS-1:0][STAMP_W-1:0] stamp,
   output logic                              found,
   output logic [BANK_W-1:0]                 pick
);
   logic [STAMP_W-1:0] best;

   // strict less-than keeps the lower index on equal stamps
   always_comb begin
      found = 1'b0;
      pick  = '0;
      best  = '1;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (legal[i] && (!found || stamp[i] < best)) begin
            found = 1'b1;
            pick  = BANK_W'(i);
            best  = stamp[i];
         end
      end
   end
endmodule

// File: rtl/chan_cmd_arbiter.sv
module chan_cmd_arbiter
   import cta_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int STAMP_W   = 8,
   parameter int T_RRD     = 4,
   parameter int T_FAW     = 20,
   parameter int FAW_ACTS  = 4,
   parameter int WL        = 7,
   parameter int CL        = 9,
   parameter int BL        = 8,
   parameter int T_WTR     = 5,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_BANKS-1:0]              cand_valid,
   input  logic [NUM_BANKS-1:0][1:0]         cand_kind,
   input  logic [NUM_BANKS-1:0][STAMP_W-1:0] cand_stamp,
   output logic [NUM_BANKS-1:0]              ack,
   output logic                              issue_valid,
   output logic [BANK_W-1:0]                 issue_bank,
   output logic [1:0]                        issue_kind
);
   localparam int BURST = BL / 2;
   localparam int W2R   = WL + BURST + T_WTR;
   localparam int R2W   = CL + BURST + 2 - WL;

   generate
      if (NUM_BANKS < 1)           begin : g_bad_banks $error("NUM_BANKS must be at least 1"); end
      if (T_RRD < 1)               begin : g_bad_rrd   $error("T_RRD must be at least 1"); end
      if (T_FAW < T_RRD)           begin : g_bad_faw   $error("T_FAW must not be below T_RRD"); end
      if (BL < 2 || (BL % 2) != 0) begin : g_bad_bl    $error("BL must be even and at least 2"); end
      if (R2W < 1)                 begin : g_bad_r2w   $error("read-to-write distance must be positive"); end
   endgenerate

   logic act_ok, rd_ok, wr_ok;
   logic act_fire, rd_fire, wr_fire;
   logic [NUM_BANKS-1:0] legal;
   logic [NUM_BANKS-1:0] is_pre;
   logic found;
   logic [BANK_W-1:0] pick;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic kind_ok;
      always_comb begin
         case (dram_cmd_e'(cand_kind[g]))
            CMD_PRE: kind_ok = 1'b1;
            CMD_ACT: kind_ok = act_ok;
            CMD_RD:  kind_ok = rd_ok;
            default: kind_ok = wr_ok;
         endcase
      end
      assign legal[g]  = cand_valid[g] && kind_ok;
      assign is_pre[g] = cand_valid[g] && (cand_kind[g] == CMD_PRE);
      assign ack[g]    = found && (pick == BANK_W'(g));

      assert_ack_has_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
         ack[g] |-> cand_valid[g]);
      assert_oldest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         issue_valid |-> !(legal[g] && ((cand_stamp[g] < cand_stamp[issue_bank]) ||
                           ((cand_stamp[g] == cand_stamp[issue_bank]) && (BANK_W'(g) < issue_bank)))));
   end

   cta_oldest_pick #(.NUM_BANKS(NUM_BANKS), .STAMP_W(STAMP_W)) u_pick (
      .legal (legal),
      .stamp (cand_stamp),
      .found (found),
      .pick  (pick)
   );

   assign issue_valid = found;
   assign issue_bank  = pick;
   assign issue_kind  = cand_kind[pick];
   assign act_fire    = found && (issue_kind == CMD_ACT);
   assign rd_fire     = found && (issue_kind == CMD_RD);
   assign wr_fire     = found && (issue_kind == CMD_WR);

   cta_act_window #(.T_RRD(T_RRD), .T_FAW(T_FAW), .FAW_ACTS(FAW_ACTS)) u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fire (act_fire),
      .act_ok   (act_ok)
   );

   cta_bus_turn #(.W2R(W2R), .R2W(R2W), .BURST(BURST)) u_turn (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_fire (rd_fire),
      .wr_fire (wr_fire),
      .rd_ok   (rd_ok),
      .wr_ok   (wr_ok)
   );

   assert_one_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack) && (issue_valid == (ack != '0)));
   assert_pre_always_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pre != '0) |-> issue_valid);

endmodule

// File: tb/chan_cmd_arbiter_tb.sv
module chan_cmd_arbiter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int SW = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic [NB-1:0]         cv;
   logic [NB-1:0][1:0]    ck;
   logic [NB-1:0][SW-1:0] cs;
   logic [NB-1:0]         ack;
   logic                  issue_valid;
   logic [1:0]            issue_bank;
   logic [1:0]            issue_kind;

   chan_cmd_arbiter #(.NUM_BANKS(NB), .STAMP_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cand_valid(cv), .cand_kind(ck), .cand_stamp(cs),
      .ack(ack), .issue_valid(issue_valid), .issue_bank(issue_bank), .issue_kind(issue_kind)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int last_act, last_rd, last_wr;
   int act_h [4];
   int issue_cyc [NB];

   initial begin
      #(CLK_PERIOD * 190000);
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   function automatic bit legal_m(input logic [1:0] k);
      case (k)
         2'd0: return 1'b1;
         2'd1: return (cyc - last_act >= 4) && (cyc - act_h[3] >= 20);
         2'd2: return (cyc - last_rd >= 4) && (cyc - last_wr >= 16);
         default: return (cyc - last_wr >= 4) && (cyc - last_rd >= 8);
      endcase
   endfunction

   function automatic string blame(input bit exp_v, input int exp_b);
      if (issue_valid && !legal_m(issue_kind)) begin
         case (issue_kind)
            2'd1: return (cyc - last_act < 4) ? "R2" : "R3";
            2'd2: return (cyc - last_wr < 16) ? "R4" : "R6";
            2'd3: return (cyc - last_rd < 8) ? "R5" : "R6";
            default: return "R7";
         endcase
      end
      if (exp_v && !issue_valid && ck[exp_b] == 2'd0) return "R7";
      if (exp_v && issue_valid) return "R8";
      return "R1";
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // one clock: compare outputs with the model, then commit what issued
   task automatic tick();
      bit exp_v, ok, had;
      int exp_b, acked;
      #1;
      exp_v = 0; exp_b = 0; had = 0; acked = 0;
      for (int b = 0; b < NB; b++)
         if (cv[b] && legal_m(ck[b]) && (!exp_v || cs[b] < cs[exp_b])) begin
            exp_v = 1; exp_b = b;
         end
      if (cv != '0 || issue_valid) begin
         checks++;
         ok = (issue_valid === exp_v) &&
              (exp_v ? (issue_bank == 2'(exp_b) && issue_kind == ck[exp_b] && ack === (4'b1 << exp_b))
                     : (ack === '0));
         if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual v=%0d bank=%0d kind=%0d ack=%b expected v=%0d bank=%0d",
                     blame(exp_v, exp_b), cyc, issue_valid, issue_bank, issue_kind, ack, exp_v, exp_b);
         end
      end
      if (issue_valid === 1'b1) begin
         had = 1; acked = int'(issue_bank);
         issue_cyc[acked] = cyc;
         case (issue_kind)
            2'd1: begin
               last_act = cyc;
               for (int j = 3; j > 0; j--) act_h[j] = act_h[j-1];
               act_h[0] = cyc;
            end
            2'd2: last_rd = cyc;
            2'd3: last_wr = cyc;
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (had) cv[acked] = 1'b0;
   endtask

   task automatic offer(input int b, input logic [1:0] k, input int s);
      cv[b] = 1'b1; ck[b] = k; cs[b] = SW'(s);
   endtask

   task automatic offer_wait(input int b, input logic [1:0] k, input int s, output int when);
      offer(b, k, s);
      for (int n = 0; n < 100 && cv[b]; n++) tick();
      when = issue_cyc[b];
   endtask

   task automatic drain();
      for (int n = 0; n < 200 && cv != '0; n++) tick();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      int t0, t1, t2, t3, t4, c0, sc, offers;
      bit reoffered;
      void'($urandom(32'h1d5e_a7b3));
      rst_n = 1'b0; cv = '0; ck = '0; cs = '0;
      last_act = -1000; last_rd = -1000; last_wr = -1000;
      foreach (act_h[j]) act_h[j] = -1000;
      foreach (issue_cyc[j]) issue_cyc[j] = -1;
      repeat (3) @(negedge clk);
      #1;
      check(issue_valid === 1'b0, "R9 idle valid in reset", issue_valid, 0);
      check(ack === '0, "R9 idle ack in reset", ack, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc = 0;

      // R9: first command after reset goes at once
      offer(1, 2'd2, 5);
      c0 = cyc;
      tick();
      check(issue_cyc[1] == c0, "R9 first read issues at once", issue_cyc[1], c0);

      // R2 / R3: four activates then a fifth into a full window
      idle(30);
      offer(0, 2'd1, 10); offer(1, 2'd1, 11); offer(2, 2'd1, 12); offer(3, 2'd1, 13);
      c0 = cyc; reoffered = 0;
      for (int n = 0; n < 40; n++) begin
         tick();
         if (!cv[0] && !reoffered) begin offer(0, 2'd1, 14); reoffered = 1; end
      end
      check(issue_cyc[1] - c0 == 4,  "R2 second activate spacing", issue_cyc[1] - c0, 4);
      check(issue_cyc[2] - c0 == 8,  "R2 third activate spacing",  issue_cyc[2] - c0, 8);
      check(issue_cyc[3] - c0 == 12, "R2 fourth activate spacing", issue_cyc[3] - c0, 12);
      check(issue_cyc[0] - c0 == 20, "R3 fifth activate waits for window", issue_cyc[0] - c0, 20);

      // R4 / R5 / R6: turnaround and burst spacing
      idle(30);
      offer_wait(2, 2'd3, 20, t1);
      offer_wait(3, 2'd2, 21, t2);
      check(t2 - t1 == 16, "R4 read after write", t2 - t1, 16);
      offer_wait(1, 2'd3, 22, t3);
      check(t3 - t2 == 8, "R5 write after read", t3 - t2, 8);
      offer_wait(0, 2'd3, 23, t4);
      check(t4 - t3 == 4, "R6 write after write", t4 - t3, 4);
      offer_wait(0, 2'd2, 24, t1);
      offer_wait(1, 2'd2, 25, t2);
      check(t2 - t1 == 4, "R6 read after read", t2 - t1, 4);

      // R7 / R8: younger legal commands pass an older blocked read
      idle(30);
      offer_wait(3, 2'd3, 29, t0);
      offer(0, 2'd2, 30); offer(2, 2'd3, 35); offer(1, 2'd0, 40);
      drain();
      check(issue_cyc[1] - t0 == 1,  "R7 precharge passes blocked commands", issue_cyc[1] - t0, 1);
      check(issue_cyc[2] - t0 == 4,  "R8 younger write passes blocked read", issue_cyc[2] - t0, 4);
      check(issue_cyc[0] - t0 == 20, "R4 old read after second write", issue_cyc[0] - t0, 20);

      // R8: tie goes to lower index, older stamp beats lower index
      offer(3, 2'd0, 50); offer(1, 2'd0, 50);
      c0 = cyc;
      drain();
      check(issue_cyc[1] == c0 && issue_cyc[3] == c0 + 1, "R8 equal stamps lower bank first",
            issue_cyc[3] - issue_cyc[1], 1);
      offer(0, 2'd0, 61); offer(2, 2'd0, 60);
      c0 = cyc;
      drain();
      check(issue_cyc[2] == c0 && issue_cyc[0] == c0 + 1, "R8 older stamp beats lower bank",
            issue_cyc[0] - issue_cyc[2], 1);

      // random rounds checked against the model every cycle
      for (int r = 0; r < 4; r++) begin
         sc = 1; offers = 0;
         for (int n = 0; n < 400 && offers < 60; n++) begin
            for (int b = 0; b < NB; b++)
               if (!cv[b] && offers < 60 && ($urandom % 10) < 3) begin
                  offer(b, 2'($urandom % 4), sc);
                  offers++;
                  if (($urandom % 4) != 0) sc++;
               end
            tick();
         end
         drain();
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule